// File: doc/BRIEF.md
# Gated Programmable Sample-Clock Divider

This block derives a slow sample clock, such as an audio frame or left/right clock, from a fast input clock. The input clock is divided by an integer set in a divide field, and the output high time is set in input-clock cycles by a separate high-count field. Both fields are loaded through a simple write port and can be read back through a read port.

A divide field of zero does not mean "divide by one". It gates the output, which then stays low. Any nonzero divide field value `val` gives a period of `val+1` input cycles. The output is high for the first `hi+1` cycles of each period, so the duty ratio is `(1+hi)/(1+val)`.

Both fields are sampled only at a period boundary. A change therefore never cuts a high or low phase short. When the block leaves the gated state, it starts a fresh period, beginning high.

Top module: `sdiv_clkgen`

## Requirements
- R1: While the divide field is 0, `clk_out` is low and static once the period in progress has completed.
- R2: With divide field `val` at 1 or more, `clk_out` repeats with a period of `val+1` input-clock cycles.
- R3: Each period starts with `clk_out` high for `hi+1` input cycles and then low for the rest of the period, where `hi` is the high-count field.
- R4: With `hi` equal to `val`, `clk_out` stays high for the whole period, which gives a constant high level.
- R5: With the divide field at all ones, the divisor reaches its maximum of 2^W.
- R6: With `val` = 1, the divisor reaches its minimum of 2.
- R7: A write to either field takes effect only at the next period boundary, so no runt pulse appears.
- R8: A high-count value larger than `val` behaves as `val`, which gives a constant high output.
- R9: A nonzero divide write made while gated is stored at the next clock edge. The edge after that starts a period with `clk_out` high.
- R10: The asynchronous active-low reset clears both fields to 0 and drives `clk_out` low.
- R11: Select value 0 addresses the divide field and select value 1 addresses the high-count field, for both writes and reads. A nonzero divide readback means the clock is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected field |
| wr_sel | input | 1 | Write field select: 0 divide, 1 high-count |
| wr_data | input | W | Write value |
| rd_sel | input | 1 | Read field select: 0 divide, 1 high-count |
| rd_data | output | W | Current value of the selected field |
| clk_out | output | 1 | Divided, gated sample clock |

## Verification
The waveform is compared cycle by cycle against a model built from the period and high-count formulas. The patterns are a mid-range ratio, the minimum divisor, the maximum divisor, `hi` equal to `val`, and `hi` above `val`. Together these separate an off-by-one in the period from one in the high phase, and expose clamping or a constant-high mistake. Two patterns write new values partway through a running period: one with new nonzero values and one with zero. The first period must stay unchanged while the next one carries the new shape, or a static low. This separates boundary-aligned updates from immediate ones.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic {
    SEL_DIV = 1'b0,
    SEL_HI  = 1'b1
  } sdiv_sel_e;
endpackage

// File: rtl/sdiv_regs.sv
module sdiv_regs
  import sdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] div_q,
  output logic [W-1:0] hi_q
);
  logic wr_div, wr_hi;

  assign wr_div = wr_en && (wr_sel == SEL_DIV);
  assign wr_hi  = wr_en && (wr_sel == SEL_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      hi_q  <= '0;
    end else begin
      if (wr_div) div_q <= wr_data;
      if (wr_hi)  hi_q  <= wr_data;
    end
  end

  always_comb begin
    if (rd_sel == SEL_HI) rd_data = hi_q;
    else                  rd_data = div_q;
  end
endmodule

// File: rtl/sdiv_seq.sv
module sdiv_seq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_q,
  input  logic [W-1:0] hi_q,
  output logic         run_q,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic [W-1:0] act_div_q,
  output logic [W-1:0] act_hi_q,
  output logic         period_end,
  output logic         load,
  output logic         stop
);
  // A high count above the divide value saturates to it.
  function automatic logic [W-1:0] clamp_hi(input logic [W-1:0] hv, input logic [W-1:0] dv);
    return (hv > dv) ? dv : hv;
  endfunction

  logic div_nz;

  assign div_nz     = (div_q != '0);
  assign period_end = run_q && (cnt_q == act_div_q);
  assign load       = div_nz && (!run_q || period_end);
  assign stop       = period_end && !div_nz;
  assign cnt_nxt    = load ? '0 : (run_q ? cnt_q + 1'b1 : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      act_div_q <= '0;
      act_hi_q  <= '0;
    end else if (load) begin
      run_q     <= 1'b1;
      cnt_q     <= '0;
      act_div_q <= div_q;
      act_hi_q  <= clamp_hi(hi_q, div_q);
    end else if (stop) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sdiv_wave.sv
module sdiv_wave #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         stop,
  input  logic         run_q,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] act_hi_q,
  output logic         clk_out
);
  function automatic logic in_high(input logic [W-1:0] c, input logic [W-1:0] h);
    return c <= h;
  endfunction

  logic out_d;

  always_comb begin
    if (load)       out_d = 1'b1;
    else if (stop)  out_d = 1'b0;
    else if (run_q) out_d = in_high(cnt_nxt, act_hi_q);
    else            out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= out_d;
  end
endmodule

// File: rtl/sdiv_clkgen.sv
module sdiv_clkgen #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         clk_out
);
  logic [W-1:0] div_q, hi_q;
  logic         run_q, period_end, load, stop;
  logic [W-1:0] cnt_q, cnt_nxt, act_div_q, act_hi_q;

  sdiv_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .div_q(div_q), .hi_q(hi_q)
  );

  sdiv_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .div_q(div_q), .hi_q(hi_q),
    .run_q(run_q), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .act_div_q(act_div_q), .act_hi_q(act_hi_q),
    .period_end(period_end), .load(load), .stop(stop)
  );

  sdiv_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .load(load), .stop(stop), .run_q(run_q),
    .cnt_nxt(cnt_nxt), .act_hi_q(act_hi_q), .clk_out(clk_out)
  );
endmodule

// File: rtl/sdiv_clkgen_chk.sv
module sdiv_clkgen_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_q,
  input logic         load,
  input logic         period_end,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] act_div_q,
  input logic [W-1:0] act_hi_q,
  input logic         clk_out
);
  AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !clk_out); // R1

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= act_div_q)); // R2

  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (clk_out == (cnt_q <= act_hi_q))); // R3

  AST_HI_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (act_hi_q <= act_div_q)); // R8

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load) |=> ($stable(act_div_q) && $stable(act_hi_q))); // R7

  AST_RISE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !period_end) |=> !$rose(clk_out)); // R7

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (clk_out && run_q && cnt_q == '0)); // R9
endmodule

bind sdiv_clkgen sdiv_clkgen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .load(load), .period_end(period_end),
  .cnt_q(cnt_q), .act_div_q(act_div_q), .act_hi_q(act_hi_q), .clk_out(clk_out)
);

// File: tb/sdiv_clkgen_test.sv
module sdiv_clkgen_test;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int GATE_WAIT = (1 << W) + 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_sel = 1'b0;
  logic [W-1:0] rd_data;
  logic         clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sdiv_clkgen #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .clk_out(clk_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one write at a falling edge; returns at the falling edge after the write lands.
  task automatic wr(input logic sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(val);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Gate, program, enable; returns at the sample of cycle 0 of the first period.
  task automatic start(input int val, input int hi);
    wr(1'b0, 0);
    repeat (GATE_WAIT) @(negedge clk);
    wr(1'b1, hi);
    wr(1'b0, val);
    @(negedge clk);
  endtask

  task automatic check_wave(input string req, input int per, input int high, input int n);
    for (int k = 0; k < n; k++) begin
      chk(req, int'(clk_out), ((k % per) < high) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 out", int'(clk_out), 0);
    rd_sel = 1'b0; #1 chk("R10 div", int'(rd_data), 0);
    rd_sel = 1'b1; #1 chk("R10 hi", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out after release", int'(clk_out), 0);
  endtask

  task automatic t_basic();
    start(3, 1);
    check_wave("R2 R3 period4 high2", 4, 2, 12);
    rd_sel = 1'b0; #1 chk("R11 div readback", int'(rd_data), 3);
    rd_sel = 1'b1; #1 chk("R11 hi readback", int'(rd_data), 1);
  endtask

  task automatic t_min();
    start(1, 0);
    check_wave("R6 period2", 2, 1, 8);
  endtask

  task automatic t_max();
    start((1 << W) - 1, 7);
    check_wave("R5 period16", 1 << W, 8, 3 << W);
  endtask

  task automatic t_full_high();
    start(5, 5);
    check_wave("R4 constant high", 6, 6, 18);
  endtask

  task automatic t_clamp();
    start(3, 9);
    check_wave("R8 clamp high", 4, 4, 12);
  endtask

  task automatic t_gate();
    start(2, 0);
    chk("R9 first cycle high", int'(clk_out), 1);
    wr(1'b0, 0);
    repeat (GATE_WAIT) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      chk("R1 gated low", int'(clk_out), 0);
      @(negedge clk);
    end
    rd_sel = 1'b0; #1 chk("R11 div zero means disabled", int'(rd_data), 0);
  endtask

  task automatic t_update();
    start(3, 1);
    for (int k = 0; k < 20; k++) begin
      int e;
      if (k < 4) e = (k < 2) ? 1 : 0;
      else       e = (((k - 4) % 8) < 4) ? 1 : 0;
      chk("R7 boundary update", int'(clk_out), e);
      if (k == 0) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = W'(3); end
      if (k == 1) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = W'(7); end
      if (k == 2) wr_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_stop();
    start(3, 1);
    for (int k = 0; k < 24; k++) begin
      int e;
      e = (k < 2) ? 1 : 0;
      chk("R7 R1 stop at boundary", int'(clk_out), e);
      if (k == 0) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = '0; end
      if (k == 1) wr_en = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_min();
    t_max();
    t_full_high();
    t_clamp();
    t_gate();
    t_update();
    t_stop();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule